// File: doc/BRIEF.md
# Asynchronous pulse capture stretcher

This block turns a very short active-low glitch into a long active-low strobe. The glitch can be around 10 ns wide and can arrive at any moment, with no relation to the system clock. It is far too narrow to be sampled, so the block never samples it. Instead the glitch asynchronously clears a two-stage register chain, and the strobe is driven low for as long as either stage holds zero.

The chain refills with ones only on a slow enable tick. A built-in counter derives this tick from the free-running clock, and by default it fires once every 100 ms at a 125 MHz clock. The strobe therefore ends on the second tick after the glitch. That gives a stretched width between one and two tick periods, depending on where the glitch falls relative to the tick.

A two-flop release synchroniser sits between the input and the chain. It makes the end of the clear land cleanly, one clock edge after another, so that a tick arriving at the same moment cannot leave the first stage undecided. The divide ratio is a parameter, so simulation can use a short period.

Top module: `pulse_stretch`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the stages are set to one and the divider is cleared. After that edge `strobe_n` reads 1 until the next input pulse.
- R2: A falling edge on `pulse_n` drives `strobe_n` to 0 at once, with no clock edge needed.
- R3: A low pulse on `pulse_n` that starts and ends between two clock edges, shorter than half a clock period, is still caught and stretched.
- R4: While `pulse_n` stays low, `strobe_n` stays 0, whatever ticks occur.
- R5: After `rst` is released, the tick fires on every TICK_DIV-th clock edge, counting from the edge that cleared the divider. `strobe_n` rises only on such an edge, or on a reset edge.
- R6: Number the clock edges after `pulse_n` returns high as 1, 2, 3 and so on. Edges 1 and 2 only release the synchroniser. `strobe_n` rises right after the second tick edge that is edge 3 or later.
- R7: A new low pulse during an active stretch clears both stages again. Timing restarts from the end of the new pulse.
- R8: For a short pulse, the number of clock edges from its release until `strobe_n` reads high lies between TICK_DIV+3 and 2*TICK_DIV+2. Both bounds are included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_n | input | 1 | Raw short pulse, active low, asynchronous to `clk` |
| strobe_n | output | 1 | Stretched strobe, active low |

## Verification
The assertions check the following on every cycle:
- the strobe is low whenever the input is sampled low;
- the strobe never rises except on a tick or reset edge;
- it stays low between ticks;
- the tick is one cycle wide;
- a held clear empties both stages.

Three things depend on the tick phase and on the timing of asynchronous events, and only the bench scenarios can show them:
- capture of sub-cycle pulses;
- the exact release edge after the synchroniser;
- the restart on a retriggering pulse and the width bounds.

The bench sweeps the release phase across a whole tick period for these.

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int unsigned TICK_DIV = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_n,
  output logic strobe_n
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;
  logic          tick;
  logic [1:0]    rel_q;
  logic          clr_n;
  logic [1:0]    stg_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge pulse_n) begin
    if (!pulse_n)  rel_q <= 2'b00;
    else if (rst)  rel_q <= 2'b11;
    else           rel_q <= {rel_q[0], 1'b1};
  end

  assign clr_n = rel_q[1];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)     stg_q <= 2'b00;
    else if (rst)   stg_q <= 2'b11;
    else if (tick)  stg_q <= {stg_q[0], 1'b1};
  end

  assign strobe_n = &stg_q;
endmodule

module pulse_stretch_chk (
  input logic       clk,
  input logic       rst,
  input logic       pulse_n,
  input logic       strobe_n,
  input logic       tick,
  input logic       clr_n,
  input logic [1:0] stg
);
  // R4
  held_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pulse_n |-> !strobe_n);
  // R5
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_n) |-> ($past(tick) || $past(rst)));
  // R6
  stay_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_n && !tick) |=> !strobe_n);
  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R2
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (stg == 2'b00));
  // R7
  stage_order_chk: assert property (@(posedge clk) disable iff (rst)
    stg[1] |-> stg[0]);
endmodule

bind pulse_stretch pulse_stretch_chk u_chk (
  .clk(clk), .rst(rst), .pulse_n(pulse_n), .strobe_n(strobe_n),
  .tick(tick), .clr_n(clr_n), .stg(stg_q)
);

// File: tb/tb_pulse_stretch.sv
`timescale 1ns/1ps
module tb_pulse_stretch;
  localparam int DIV = 16;

  logic clk = 0, rst = 1, pulse_n = 1;
  wire  strobe_n;

  pulse_stretch #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .pulse_n(pulse_n), .strobe_n(strobe_n));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0, cmp_on = 0;
  string cur_req = "R1";
  int m_cnt = 0, m_ticks = 2, m_since = 99;
  int cyc = 0, first_rise = -1;
  logic prev_s = 1;

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(negedge pulse_n) begin
    m_since = 0;
    m_ticks = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ticks = 2; m_since = 99; cyc = 0;
    end else begin
      bit t;
      cyc++;
      t = (m_cnt == DIV - 1);
      m_cnt = t ? 0 : m_cnt + 1;
      if (!pulse_n) begin
        m_since = 0; m_ticks = 0;
      end else begin
        if (m_since < 99) m_since++;
        if (t && m_since >= 3 && m_ticks < 2) m_ticks++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(strobe_n, (m_ticks >= 2) && pulse_n, cur_req);
      if (strobe_n && !prev_s) begin
        if (first_rise < 0) first_rise = cyc;
        else check(((cyc - first_rise) % DIV) == 0, 1'b1, "R5");
      end
      prev_s = strobe_n;
    end
  end

  task automatic short_pulse();
    @(negedge clk); #1 pulse_n = 0;
    #1 check(strobe_n, 1'b0, "R2");
    #1 pulse_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    #1 check(strobe_n, 1'b1, "R1");
    idle(5);

    cur_req = "R3";
    short_pulse();
    idle(2);
    cur_req = "R6";
    idle(50);

    cur_req = "R4";
    @(negedge clk); #2 pulse_n = 0;
    idle(3 * DIV + 2);
    @(negedge clk); #1 check(strobe_n, 1'b0, "R4");
    #1 pulse_n = 1;
    cur_req = "R6";
    idle(3 * DIV);

    cur_req = "R7";
    short_pulse();
    idle(DIV + 1);
    short_pulse();
    @(negedge clk); #1 check(strobe_n, 1'b0, "R7");
    idle(3 * DIV);

    cur_req = "R6";
    for (int i = 0; i < DIV; i++) begin
      int n;
      idle(i + 1);
      short_pulse();
      n = 0;
      while (strobe_n !== 1'b1 && n < 4 * DIV) begin
        @(posedge clk); n++; #1;
      end
      check((n >= DIV + 3) && (n <= 2 * DIV + 2), 1'b1, "R8");
      if (!((n >= DIV + 3) && (n <= 2 * DIV + 2)))
        $display("  R8 width %0d edges, bounds %0d..%0d", n, DIV + 3, 2 * DIV + 2);
    end
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule